// File: doc/BRIEF.md
# Cascadable serial configuration bit ROM

This block is a one-bit-wide read-only store that streams a fixed configuration bitstream to a downstream consumer, one bit per clock. An internal address counter walks through a parameterised memory. The memory contents come from a constant pattern computed at elaboration, so no external file is needed. The consumer supplies the clock, keeps the unit enabled for as many bits as it needs, and then disables it. The block holds its position while it is disabled.

Several units share one clock and one serial data line. Each unit gives an active-low cascade enable to the next one when it reaches its last bit, so a chain reads out as one continuous stream. One pin serves as both reset and output enable. A parameter selects whether that pin is active high or active low. The data output comes with a drive-enable, so the shared line can be resolved outside the block.

Top module: `serial_cfg_rom`

## Requirements
- R1: When the reset/output-enable pin is at its reset level at a rising clock edge, the counter returns to bit 0, the terminal state clears, `data_oe` reads 0 and `ceo_n` reads 1 after that edge. The next enabled edge after reset delivers bit 0.
- R2: With `RST_ACTIVE_HIGH`=1 the reset level of `rst_oe` is 1. With `RST_ACTIVE_HIGH`=0 the reset level is 0.
- R3: An enabled edge is a rising edge with `ce_n`=0 and `rst_oe` not at its reset level. After the k-th enabled edge since reset (k from 1 to DEPTH), `data_oe`=1 and `data_o` carries stored bit k-1.
- R4: Stored bit i equals bit 2 of (i*PAT_MUL + PAT_ADD).
- R5: After a rising edge with `ce_n`=1, `data_oe`=0 and the address is held. The next enabled edge delivers the bit that follows the last one delivered.
- R6: `ceo_n` goes to 0 on the same edge that delivers bit DEPTH-1. Before that edge it is 1.
- R7: After the terminal edge, further enabled edges give `data_oe`=0 and `ceo_n`=0. The counter does not wrap, so no bit is repeated.
- R8: A rising edge with `ce_n`=1 sets `ceo_n` to 1. When the unit is enabled again after terminal count, `ceo_n` returns to 0 and the output stays released.
- R9: Two units, where the second unit's `ce_n` is fed by the first unit's `ceo_n`, drive the shared line one at a time. Together they deliver 2*DEPTH bits over 2*DEPTH consecutive enabled edges with no gap.
- R10: Asserting reset in the middle of a stream releases the output after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock from the consumer |
| ce_n | input | 1 | Active-low chip enable |
| rst_oe | input | 1 | Combined reset/output enable; polarity set by RST_ACTIVE_HIGH |
| data_o | output | 1 | Serial data bit, 0 while released |
| data_oe | output | 1 | High when this unit drives the shared data line |
| ceo_n | output | 1 | Active-low cascade enable for the next unit |

## Verification
The hardest situation to reach is the handover between units. The first unit has to release the line on the same edge that the second unit starts to drive it. After that, both units must stay silent while the consumer keeps clocking. The bench chains two units with small depth, clocks through both memories, and continues past the end, checking every bit position against the arithmetic pattern. It also confirms that only one unit drives at a time. It then takes chip enable away and restores it after terminal count, and breaks a stream with a pause and with a mid-stream reset.

// File: rtl/scr_pkg.sv
package scr_pkg;
  // Stored bit i is bit 2 of (i*mul + add).
  function automatic logic pattern_bit(int unsigned idx, int unsigned mul,
                                       int unsigned add);
    int unsigned v;
    v = idx * mul + add;
    return v[2];
  endfunction
endpackage

// File: rtl/scr_pin_decode.sv
module scr_pin_decode #(
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic ce_n,
  input  logic rst_oe,
  output logic in_reset,
  output logic enabled
);
  generate
    if (RST_ACTIVE_HIGH) begin : g_hi
      assign in_reset = rst_oe;
    end else begin : g_lo
      assign in_reset = ~rst_oe;
    end
  endgenerate

  assign enabled = ~in_reset & ~ce_n;
endmodule

// File: rtl/scr_addr_ctr.sv
module scr_addr_ctr #(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          in_reset,
  input  logic          enabled,
  output logic [AW-1:0] addr,
  output logic          spent,
  output logic          at_last
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign at_last = (addr == LAST) && !spent;

  always_ff @(posedge clk) begin
    if (in_reset) begin
      addr  <= '0;
      spent <= 1'b0;
    end else if (enabled && !spent) begin
      if (addr == LAST) spent <= 1'b1;
      else              addr  <= addr + 1'b1;
    end
  end

  // R1: reset brings the counter home
  p_reset_home_r1: assert property (@(posedge clk)
    in_reset |=> (addr == '0) && !spent);

  // R5: a disabled unit keeps its position
  p_hold_disabled_r5: assert property (@(posedge clk) disable iff (in_reset)
    !enabled |=> $stable(addr) && $stable(spent));

  // R7: once spent, the counter never wraps
  p_saturate_r7: assert property (@(posedge clk) disable iff (in_reset)
    spent |=> spent && $stable(addr));
endmodule

// File: rtl/scr_bit_store.sv
module scr_bit_store #(
  parameter int DEPTH   = 256,
  parameter int PAT_MUL = 7,
  parameter int PAT_ADD = 0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output logic          rd_bit
);
  import scr_pkg::*;

  logic rom [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
      assign rom[i] = pattern_bit(i, PAT_MUL, PAT_ADD);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rd_en) rd_bit <= rom[addr];
  end
endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom #(
  parameter int DEPTH           = 256,
  parameter int PAT_MUL         = 7,
  parameter int PAT_ADD         = 0,
  parameter bit RST_ACTIVE_HIGH = 1'b1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic ce_n,
  input  logic rst_oe,
  output logic data_o,
  output logic data_oe,
  output logic ceo_n
);
  logic          in_reset, enabled, spent, at_last, raw_bit;
  logic [AW-1:0] addr;

  scr_pin_decode #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_pins (
    .ce_n(ce_n), .rst_oe(rst_oe), .in_reset(in_reset), .enabled(enabled));

  scr_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk(clk), .in_reset(in_reset), .enabled(enabled),
    .addr(addr), .spent(spent), .at_last(at_last));

  scr_bit_store #(.DEPTH(DEPTH), .PAT_MUL(PAT_MUL), .PAT_ADD(PAT_ADD)) u_rom (
    .clk(clk), .rd_en(enabled && !spent), .addr(addr), .rd_bit(raw_bit));

  always_ff @(posedge clk) begin
    if (in_reset || !enabled) begin
      data_oe <= 1'b0;
      ceo_n   <= 1'b1;
    end else begin
      data_oe <= !spent;
      ceo_n   <= !(spent || at_last);
    end
  end

  assign data_o = raw_bit & data_oe;

  // R10: reset releases the line
  p_reset_release_r10: assert property (@(posedge clk)
    in_reset |=> !data_oe && ceo_n);

  // R5: no drive after a disabled edge
  p_release_off_r5: assert property (@(posedge clk) disable iff (in_reset)
    ce_n |=> !data_oe);

  // R7: spent unit stays silent and keeps cascade asserted
  p_spent_quiet_r7: assert property (@(posedge clk) disable iff (in_reset)
    (enabled && spent) |=> !data_oe && !ceo_n);

  // R6: cascade never asserted together with drive except on the last bit
  p_ceo_last_r6: assert property (@(posedge clk) disable iff (in_reset)
    (enabled && !spent && !at_last) |=> ceo_n && data_oe);
endmodule

// File: tb/sim_serial_cfg_rom.sv
module sim_serial_cfg_rom;
  localparam int D = 16;
  localparam int MUL = 7;
  localparam int A0 = 0, A1 = 5, A2 = 9;

  logic clk = 1'b0;
  logic ce_n = 1'b0, rst = 1'b1, rst_lo = 1'b0;
  logic d0, oe0, ceo0, d1, oe1, ceo1, d2, oe2, ceo2;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  serial_cfg_rom #(.DEPTH(D), .PAT_MUL(MUL), .PAT_ADD(A0), .RST_ACTIVE_HIGH(1'b1)) u0 (
    .clk(clk), .ce_n(ce_n), .rst_oe(rst), .data_o(d0), .data_oe(oe0), .ceo_n(ceo0));
  serial_cfg_rom #(.DEPTH(D), .PAT_MUL(MUL), .PAT_ADD(A1), .RST_ACTIVE_HIGH(1'b1)) u1 (
    .clk(clk), .ce_n(ceo0), .rst_oe(rst), .data_o(d1), .data_oe(oe1), .ceo_n(ceo1));
  serial_cfg_rom #(.DEPTH(D), .PAT_MUL(MUL), .PAT_ADD(A2), .RST_ACTIVE_HIGH(1'b0)) u2 (
    .clk(clk), .ce_n(1'b0), .rst_oe(rst_lo), .data_o(d2), .data_oe(oe2), .ceo_n(ceo2));

  function automatic logic exp_bit(int i, int add);
    return 1'(((i * MUL + add) >> 2) & 1);
  endfunction

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #5000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 oe", oe0, 1'b0); chk("R1 ceo", ceo0, 1'b1);
    rst = 1'b0;
    // R9 cascade over both memories, R3/R4/R6 on u0
    for (int k = 1; k <= 2 * D; k++) begin
      tick();
      chk("R9 single driver", oe0 & oe1, 1'b0);
      chk("R9 someone drives", oe0 | oe1, 1'b1);
      if (k <= D) begin
        chk("R3 oe", oe0, 1'b1);
        chk("R4 bit", d0, exp_bit(k - 1, A0));
        chk("R6 ceo", ceo0, (k == D) ? 1'b0 : 1'b1);
      end else begin
        chk("R9 bit", d1, exp_bit(k - 1 - D, A1));
      end
    end
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R7 u0 quiet", oe0, 1'b0); chk("R7 u1 quiet", oe1, 1'b0);
      chk("R7 ceo held", ceo0, 1'b0);
    end
    ce_n = 1'b1; tick();
    chk("R8 ceo off", ceo0, 1'b1);
    ce_n = 1'b0; tick();
    chk("R8 ceo back", ceo0, 1'b0); chk("R8 no drive", oe0, 1'b0);
    rst = 1'b1; tick();
    chk("R1 oe after reset", oe0, 1'b0); chk("R1 ceo after reset", ceo0, 1'b1);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick(); chk("R3 bit", d0, exp_bit(k, A0));
    end
    ce_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick(); chk("R5 released", oe0, 1'b0);
    end
    ce_n = 1'b0; tick();
    chk("R5 resume oe", oe0, 1'b1); chk("R5 resume bit", d0, exp_bit(3, A0));
    tick(); chk("R5 next bit", d0, exp_bit(4, A0));
    rst = 1'b1; tick();
    chk("R10 release", oe0, 1'b0);
    rst = 1'b0; tick();
    chk("R1 restart oe", oe0, 1'b1); chk("R1 restart bit", d0, exp_bit(0, A0));
    // R2 active-low polarity unit
    chk("R2 low level resets", oe2, 1'b0); chk("R2 ceo idle", ceo2, 1'b1);
    rst_lo = 1'b1;
    for (int k = 0; k < D; k++) begin
      tick();
      chk("R2 oe", oe2, 1'b1); chk("R2 bit", d2, exp_bit(k, A2));
    end
    chk("R2 ceo", ceo2, 1'b0);
    rst_lo = 1'b0; tick();
    chk("R2 reset", oe2, 1'b0); chk("R2 reset ceo", ceo2, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule